// File: doc/BRIEF.md
# Four-Channel Pulse Generator with Buffered Settings

This block produces four independent rectangular waveforms from one input clock. Each channel has two settings: a cycle count for the whole repetition interval and a cycle count for the low stretch at the start of that interval. Software programs the settings through a 32-bit word-addressed register port. A set of shared registers holds one bit per channel for run, reload request, pin enable, polarity and the end-of-interval flag.

The running waveform never reads the programmable settings directly. When a channel's run bit is written from 0 to 1, the channel copies both settings into private working registers. After that, new values can be written freely without touching the output. They reach the waveform only after software raises and then clears that channel's reload bit, and even then only at the next interval boundary, so no shortened or stretched interval appears. A low count of zero gives a steady high level, and a low count at or above the interval length gives a steady low level.

Top module: `pwm_multi`

## Requirements
- R1: Channel n's low-count register is at byte offset 8n and its interval register at 8n+4. The shared registers are polarity at 0x40, run at 0x44, end flag at 0x48, reload at 0x4C and pin enable at 0xD0, with bit n for channel n. Count fields occupy bits [29:0] and bits [31:30] read as zero. The polarity register stores and returns its value. Unmapped offsets read zero.
- R2: After reset, every interval register reads 2, every low-count register reads 1, all shared registers read 0, and both output buses are all zero.
- R3: In the first clock cycle after the edge that sets run bit n, channel n is at count 0. For each interval of P cycles with low count L, the output is low for cycles 0..L-1 and high for cycles L..P-1, after which it repeats.
- R4: A low count of 0 gives a constant high output.
- R5: A low count greater than or equal to the interval length keeps the output low for the whole interval.
- R6: A 0-to-1 write of run bit n captures that channel's current settings. Later writes to its settings registers leave the waveform unchanged until a reload takes place.
- R7: While channel n runs, writing reload bit n as 1 and then as 0 applies the latest settings starting at the first cycle of the next interval. The interval in progress completes unchanged.
- R8: Clearing run bit n drives output n low from the next cycle. A later 0-to-1 write restarts the channel at count 0 with the settings then in the registers.
- R9: pin-enable output n (`pwm_oe[n]`) is high only when both pin-enable bit n and run bit n are set. Otherwise `pwm_out[n]` stays low. pwm_oe changes only in the cycle after a register write.
- R10: End-flag bit n (offset 0x48, bit n) is high for exactly one cycle: the first cycle of each new interval of a running channel. It is never set for a stopped channel.
- R11: An interval setting below 2 is treated as 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 4 | Waveform level per channel |
| pwm_oe | output | 4 | Pin drive enable per channel |

## Verification
The register file and the working copies are separate state, so they can disagree internally while the register readback still looks correct. The bench therefore judges the working copies only through the waveform, cycle by cycle. If the capture or reload path latched the wrong value or fired on the wrong edge, the low/high split would be wrong within the first interval after the start or the reload. A reload applied too early would shorten the interval in progress, and a stale reload request would alter a period that should not change. Counter or boundary faults show up as a misplaced or doubled end flag in the first cycle of the next interval.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int NCH = 4;
    localparam int CW  = 30;
    localparam int AW  = 8;
    localparam int DW  = 32;

    localparam logic [AW-1:0] OFS_LOW_BASE = 8'h00;
    localparam logic [AW-1:0] OFS_PER_BASE = 8'h04;
    localparam int            CH_STRIDE    = 8;
    localparam logic [AW-1:0] OFS_POL      = 8'h40;
    localparam logic [AW-1:0] OFS_RUN      = 8'h44;
    localparam logic [AW-1:0] OFS_DONE     = 8'h48;
    localparam logic [AW-1:0] OFS_UPD      = 8'h4C;
    localparam logic [AW-1:0] OFS_OE       = 8'hD0;

    localparam logic [CW-1:0] RST_PER = CW'(2);
    localparam logic [CW-1:0] RST_LOW = CW'(1);
    localparam logic [CW-1:0] MIN_PER = CW'(2);

    typedef struct packed {
        logic [CW-1:0] per;
        logic [CW-1:0] low;
    } wave_cfg_t;

    function automatic logic [CW-1:0] eff_period(input logic [CW-1:0] p);
        return (p < MIN_PER) ? MIN_PER : p;
    endfunction

    function automatic logic [DW-1:0] zext(input logic [CW-1:0] v);
        return {{(DW-CW){1'b0}}, v};
    endfunction

    function automatic logic [AW-1:0] low_addr(input int ch);
        return AW'(int'(OFS_LOW_BASE) + CH_STRIDE * ch);
    endfunction

    function automatic logic [AW-1:0] per_addr(input int ch);
        return AW'(int'(OFS_PER_BASE) + CH_STRIDE * ch);
    endfunction

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_pkg::*;
#(
    parameter int N_CH = NCH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    input  logic [N_CH-1:0]       done_in,
    output wave_cfg_t [N_CH-1:0]  cfg,
    output logic [N_CH-1:0]       run,
    output logic [N_CH-1:0]       oe,
    output logic [N_CH-1:0]       start_rise,
    output logic [N_CH-1:0]       upd_fall
);

    logic [N_CH-1:0]         pol_q, run_q, upd_q, oe_q;
    logic [N_CH-1:0][CW-1:0] low_q, per_q;

    logic wr_pol, wr_run, wr_upd, wr_oe;
    assign wr_pol = wr && (addr == OFS_POL);
    assign wr_run = wr && (addr == OFS_RUN);
    assign wr_upd = wr && (addr == OFS_UPD);
    assign wr_oe  = wr && (addr == OFS_OE);

    logic unused_hi;
    assign unused_hi = ^wdata[DW-1:CW];

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q <= '0;
            run_q <= '0;
            upd_q <= '0;
            oe_q  <= '0;
        end else begin
            if (wr_pol) pol_q <= wdata[N_CH-1:0];
            if (wr_run) run_q <= wdata[N_CH-1:0];
            if (wr_upd) upd_q <= wdata[N_CH-1:0];
            if (wr_oe)  oe_q  <= wdata[N_CH-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_CH; i++) begin
                low_q[i] <= RST_LOW;
                per_q[i] <= RST_PER;
            end
        end else if (wr) begin
            for (int i = 0; i < N_CH; i++) begin
                if (addr == low_addr(i)) low_q[i] <= wdata[CW-1:0];
                if (addr == per_addr(i)) per_q[i] <= wdata[CW-1:0];
            end
        end
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        assign start_rise[g] = wr_run & wdata[g] & ~run_q[g];
        assign upd_fall[g]   = wr_upd & ~wdata[g] & upd_q[g];
        assign cfg[g]        = '{per: per_q[g], low: low_q[g]};
    end

    assign run = run_q;
    assign oe  = oe_q;

    always_comb begin
        rdata = '0;
        if (addr == OFS_POL)  rdata = DW'(pol_q);
        if (addr == OFS_RUN)  rdata = DW'(run_q);
        if (addr == OFS_DONE) rdata = DW'(done_in);
        if (addr == OFS_UPD)  rdata = DW'(upd_q);
        if (addr == OFS_OE)   rdata = DW'(oe_q);
        for (int i = 0; i < N_CH; i++) begin
            if (addr == low_addr(i)) rdata = zext(low_q[i]);
            if (addr == per_addr(i)) rdata = zext(per_q[i]);
        end
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      start_rise,
    input  logic      upd_fall,
    input  wave_cfg_t cfg,
    output logic      wave,
    output logic      done
);

    wave_cfg_t     work_q;
    logic [CW-1:0] cnt_q;
    logic          pend_q;
    logic          last;

    assign last = (cnt_q >= (eff_period(work_q.per) - CW'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '{per: RST_PER, low: RST_LOW};
            cnt_q  <= '0;
            pend_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start_rise) begin
                work_q <= cfg;
                cnt_q  <= '0;
                pend_q <= 1'b0;
            end else if (!run) begin
                cnt_q  <= '0;
                pend_q <= 1'b0;
            end else if (last) begin
                cnt_q  <= '0;
                done   <= 1'b1;
                pend_q <= 1'b0;
                if (pend_q || upd_fall) work_q <= cfg;
            end else begin
                cnt_q <= cnt_q + CW'(1);
                if (upd_fall) pend_q <= 1'b1;
            end
        end
    end

    assign wave = run && (cnt_q >= work_q.low);

endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
    import pwm_pkg::*;
#(
    parameter int N_CH = NCH
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr,
    input  logic [7:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic [N_CH-1:0] pwm_out,
    output logic [N_CH-1:0] pwm_oe
);

    wave_cfg_t [N_CH-1:0] cfg_vec;
    logic [N_CH-1:0] run_vec, oe_vec, done_vec, wave_vec;
    logic [N_CH-1:0] rise_vec, fall_vec;

    pwm_regfile #(.N_CH(N_CH)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .rdata      (bus_rdata),
        .done_in    (done_vec),
        .cfg        (cfg_vec),
        .run        (run_vec),
        .oe         (oe_vec),
        .start_rise (rise_vec),
        .upd_fall   (fall_vec)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        pwm_channel u_chan (
            .clk        (clk),
            .rst        (rst),
            .run        (run_vec[g]),
            .start_rise (rise_vec[g]),
            .upd_fall   (fall_vec[g]),
            .cfg        (cfg_vec[g]),
            .wave       (wave_vec[g]),
            .done       (done_vec[g])
        );
    end

    assign pwm_oe  = oe_vec & run_vec;
    assign pwm_out = wave_vec & pwm_oe;

endmodule

// File: rtl/pwm_multi_sva.sv
module pwm_multi_sva #(
    parameter int N_CH = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            bus_wr,
    input logic [N_CH-1:0] run_vec,
    input logic [N_CH-1:0] done_vec,
    input logic [N_CH-1:0] pwm_out,
    input logic [N_CH-1:0] pwm_oe
);

    // R2: outputs quiet in the first cycle after reset
    a_r2_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pwm_out == '0 && pwm_oe == '0));

    // R9: pin enable moves only after a register write
    a_r9_oe_needs_write: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_wr) |-> $stable(pwm_oe));

    for (genvar g = 0; g < N_CH; g++) begin : g_chk
        // R10: end flag lasts a single cycle
        a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
            done_vec[g] |=> !done_vec[g]);
        // R10: a stopped channel raises no end flag
        a_r10_no_done_stopped: assert property (@(posedge clk) disable iff (rst)
            !run_vec[g] |=> !done_vec[g]);
    end

endmodule

bind pwm_multi pwm_multi_sva #(.N_CH(N_CH)) u_sva (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .run_vec  (run_vec),
    .done_vec (done_vec),
    .pwm_out  (pwm_out),
    .pwm_oe   (pwm_oe)
);

// File: tb/pwm_multi_bench.sv
module pwm_multi_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out, pwm_oe;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        int    ch;
        bit    val;
        string tag;
    } exp_t;
    exp_t sq[$];

    always #10 clk = ~clk;

    pwm_multi u_pwm_multi (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out),
        .pwm_oe    (pwm_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #2;
        check(tag, bus_rdata, exp);
    endtask

    task automatic push(input int ch, input bit v, input int n, input string tag);
        for (int k = 0; k < n; k++) sq.push_back('{ch: ch, val: v, tag: tag});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (sq.size() != 0) @(negedge clk);
    endtask

    // monitor: one expected level per cycle, sampled just after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sq.size() > 0) begin
                exp_t it;
                it = sq.pop_front();
                check(it.tag, 32'(pwm_out[it.ch]), 32'(it.val));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        check("R2 pwm_out", 32'(pwm_out), 32'h0);
        check("R2 pwm_oe", 32'(pwm_oe), 32'h0);
        rd_chk("R2 low0", 8'h00, 32'd1);
        rd_chk("R2 per0", 8'h04, 32'd2);
        rd_chk("R2 per3", 8'h1C, 32'd2);
        rd_chk("R2 run", 8'h44, 32'd0);
        rd_chk("R2 oe", 8'hD0, 32'd0);
        rd_chk("R2 done", 8'h48, 32'd0);
        @(negedge clk);

        // R1 field width, polarity storage, unmapped offset
        wr(8'h1C, 32'hFFFF_FFFF);
        rd_chk("R1 per3 upper bits", 8'h1C, 32'h3FFF_FFFF);
        wr(8'h40, 32'h5);
        rd_chk("R1 polarity", 8'h40, 32'h5);
        rd_chk("R1 unmapped", 8'h80, 32'h0);
        @(negedge clk);

        // R3 / R6 / R7 / R10 on channel 0: L=3 P=8, then reload to L=6 P=10
        wr(8'h00, 32'd3);
        wr(8'h04, 32'd8);
        wr(8'hD0, 32'h1);
        wr(8'h44, 32'h1);
        push(0, 1'b0, 3, "R3 low part");
        push(0, 1'b1, 5, "R3 R6 high part");
        for (int p = 0; p < 2; p++) begin
            push(0, 1'b0, 6, "R7 new low");
            push(0, 1'b1, 4, "R7 new high");
        end
        wr(8'h00, 32'd6);
        wr(8'h04, 32'd10);
        wr(8'h4C, 32'h1);
        wr(8'h4C, 32'h0);
        check("R9 oe ch0", 32'(pwm_oe[0]), 32'h1);
        idle(4);
        rd_chk("R10 end flag set", 8'h48, 32'h1);
        @(negedge clk);
        rd_chk("R10 end flag single", 8'h48, 32'h0);
        rd_chk("R1 low0 readback", 8'h00, 32'd6);
        drain();

        // R4 then R5 on channel 1
        wr(8'h08, 32'd0);
        wr(8'h0C, 32'd5);
        wr(8'hD0, 32'h3);
        wr(8'h44, 32'h3);
        push(1, 1'b1, 5, "R4 constant high");
        push(1, 1'b0, 10, "R5 low whole period");
        wr(8'h08, 32'd7);
        wr(8'h4C, 32'h2);
        wr(8'h4C, 32'h0);
        drain();

        // R6 setting write without reload leaves channel 1 unchanged
        wr(8'h08, 32'd0);
        push(1, 1'b0, 8, "R6 no reload");
        drain();

        // R8 stop and restart channel 1 with fresh settings
        wr(8'h44, 32'h1);
        check("R8 stopped out", 32'(pwm_out[1]), 32'h0);
        check("R9 stopped oe", 32'(pwm_oe[1]), 32'h0);
        wr(8'h08, 32'd2);
        wr(8'h0C, 32'd4);
        wr(8'h44, 32'h3);
        for (int p = 0; p < 3; p++) begin
            push(1, 1'b0, 2, "R8 restart low");
            push(1, 1'b1, 2, "R8 restart high");
        end
        drain();

        // R9 gating on channel 2
        wr(8'h10, 32'd0);
        wr(8'h14, 32'd4);
        wr(8'h44, 32'h7);
        check("R9 ungated out", 32'(pwm_out[2]), 32'h0);
        check("R9 ungated oe", 32'(pwm_oe[2]), 32'h0);
        @(negedge clk);
        check("R9 ungated out later", 32'(pwm_out[2]), 32'h0);
        wr(8'hD0, 32'h7);
        push(2, 1'b1, 4, "R9 enabled high");
        check("R9 oe ch2", 32'(pwm_oe[2]), 32'h1);
        drain();

        // R11 interval setting 0 acts as 2 on channel 3
        wr(8'h1C, 32'd0);
        wr(8'h18, 32'd1);
        wr(8'hD0, 32'hF);
        wr(8'h44, 32'hF);
        for (int p = 0; p < 3; p++) begin
            push(3, 1'b0, 1, "R11 min period low");
            push(3, 1'b1, 1, "R11 min period high");
        end
        drain();
        rd_chk("R11 stored value", 8'h1C, 32'd0);
        @(negedge clk);

        finish_run();
    end

endmodule